// File: doc/BRIEF.md
# RAID-6 P/Q Syndrome Generator

This block computes the two RAID-6 check words for one stripe position. Data words stream in one disk at a time, starting at the highest-numbered data disk and working down to disk 0. The engine keeps two accumulators. P is the plain XOR of every word. Q is built by Horner's rule over GF(2^8): before each new word is XORed in, every byte of Q is doubled in the field, using the reduction constant 0x1d.

A word flagged as last closes the stripe. In the next cycle the finished P and Q are presented on a valid/ready output and held there until the consumer accepts them. While a result waits, the input is stalled, so no word can be lost. After the result is taken, the next accepted word starts a fresh stripe.

The word width is set by the parameter `LANES`, which gives the number of byte lanes: 16 or 32. The lanes are processed independently and in parallel.

Top module: `pq_syndrome`

## Requirements
- R1: After a synchronous active-high reset, `out_valid` is 0, `in_ready` is 1, and `out_p` and `out_q` both read zero.
- R2: The first word accepted in a stripe loads both accumulators with that word, with no other contribution.
- R3: Every later word d in the stripe updates P as P xor d, so the final P is the XOR of all the stripe's words.
- R4: Every later word d updates Q as mul2(Q) xor d, so the final Q is the Horner sum when words are fed from the highest disk down to disk 0.
- R5: mul2 works on each byte on its own. Bit 7 of the byte is tested (bytes 0x80 to 0xFF count as negative). The byte is shifted left one place and its carry is dropped. If bit 7 was set, 0x1d is then XORed in. For example: 0x80 gives 0x1d, 0xFF gives 0xE3, and 0x7F gives 0xFE.
- R6: The byte lanes do not interact: a bit 7 carry in one byte never changes a neighbouring byte. This holds for both 16-lane and 32-lane widths.
- R7: A stripe of exactly one word (first word also flagged last) yields P = Q = that word.
- R8: `out_valid` rises in the cycle after the last word is accepted. It then stays high with `out_p` and `out_q` unchanged until a cycle in which `out_ready` is high.
- R9: `in_ready` is 0 while `out_valid` is 1. A word offered during that time is not accepted and changes neither the output nor the next stripe.
- R10: Once a result is accepted, `out_valid` falls in the next cycle, and the next accepted word is treated as the first word of a new stripe.
- R11: A reset in the middle of a stripe discards the partial accumulation. The next accepted word is then treated as a first word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input word offered |
| in_ready | output | 1 | Engine can take a word |
| in_last | input | 1 | Offered word is the stripe's final (disk 0) word |
| in_data | input | 8*LANES | Data word from one disk |
| out_valid | output | 1 | P and Q are complete |
| out_ready | input | 1 | Consumer takes P and Q |
| out_p | output | 8*LANES | XOR parity |
| out_q | output | 8*LANES | GF(2^8) Horner syndrome |

## Verification
The assertions check the handshake on every cycle: the input stall while a result is pending, the output holding steady until it is taken, `out_valid` following a last word by one cycle, and its fall after acceptance. The arithmetic can only be shown by the bench's scenarios, which compare P and Q against an independent byte-wise model. These scenarios cover the field-doubling corner bytes (0x80, 0xFF, 0x7F), lane independence, single-word stripes, words ignored while stalled, and a reset in mid-stripe.

// File: rtl/pq_syndrome.sv
module pq_syndrome #(
  parameter int LANES = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic               in_last,
  input  logic [8*LANES-1:0] in_data,
  output logic               out_valid,
  input  logic               out_ready,
  output logic [8*LANES-1:0] out_p,
  output logic [8*LANES-1:0] out_q
);
  localparam int W = 8 * LANES;
  localparam logic [7:0] POLY = 8'h1d;

  logic [W-1:0] p_acc, q_acc, q_dbl;
  logic         mid;
  logic         pend;
  logic         take;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign q_dbl[8*i +: 8] = {q_acc[8*i +: 7], 1'b0} ^ (q_acc[8*i+7] ? POLY : 8'h00);
  end

  assign in_ready  = !pend;
  assign take      = in_valid && in_ready;
  assign out_valid = pend;
  assign out_p     = p_acc;
  assign out_q     = q_acc;

  always_ff @(posedge clk) begin
    if (rst) begin
      p_acc <= '0;
      q_acc <= '0;
      mid   <= 1'b0;
      pend  <= 1'b0;
    end else begin
      if (take) begin
        p_acc <= mid ? (p_acc ^ in_data) : in_data;
        q_acc <= mid ? (q_dbl ^ in_data) : in_data;
        mid   <= !in_last;
        pend  <= in_last;
      end else if (pend && out_ready) begin
        pend <= 1'b0;
      end
    end
  end

  assert_stall_while_pending_R9: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> !in_ready);

  assert_result_holds_R8: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_p) && $stable(out_q)));

  assert_valid_after_last_R8: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready && in_last) |=> out_valid);

  assert_drop_after_accept_R10: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_ready) |=> !out_valid);

  assert_idle_after_reset_R1: assert property (@(posedge clk)
    rst |=> (!out_valid && in_ready));
endmodule

// File: tb/pq_syndrome_bench.sv
module pq_syndrome_bench;
  localparam int LANES = 16;
  localparam int W = 8 * LANES;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic in_last = 1'b0;
  logic [W-1:0] in_data = '0;
  logic out_ready = 1'b0;
  logic in_ready, out_valid;
  logic [W-1:0] out_p, out_q;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  pq_syndrome #(.LANES(LANES)) u_pq_syndrome (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_last(in_last), .in_data(in_data), .out_valid(out_valid),
    .out_ready(out_ready), .out_p(out_p), .out_q(out_q)
  );

  function automatic logic [W-1:0] gf_dbl(logic [W-1:0] v);
    logic [W-1:0] r;
    for (int i = 0; i < LANES; i++) begin
      logic [7:0] b;
      b = v[8*i +: 8];
      r[8*i +: 8] = (b << 1) ^ ((b >= 8'h80) ? 8'h1d : 8'h00);
    end
    return r;
  endfunction

  function automatic logic [W-1:0] rnd_word();
    logic [W-1:0] r;
    for (int i = 0; i < W / 32; i++) r[32*i +: 32] = $urandom;
    return r;
  endfunction

  task automatic chk(string tag, logic [W-1:0] act, logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic send(logic [W-1:0] d, logic last);
    in_valid = 1'b1;
    in_data  = d;
    in_last  = last;
    @(negedge clk);
    in_valid = 1'b0;
    in_last  = 1'b0;
  endtask

  task automatic accept();
    out_ready = 1'b1;
    @(negedge clk);
    out_ready = 1'b0;
    chk("R10 out_valid falls after accept", W'(out_valid), W'(0));
    chk("R10 in_ready back", W'(in_ready), W'(1));
  endtask

  task automatic run_stripe(int n, string tag);
    logic [W-1:0] ep, eq, d;
    for (int k = 0; k < n; k++) begin
      d = rnd_word();
      if (k == 0) begin ep = d; eq = d; end
      else begin ep = ep ^ d; eq = gf_dbl(eq) ^ d; end
      send(d, k == n - 1);
    end
    chk({tag, " out_valid after last (R8)"}, W'(out_valid), W'(1));
    chk({tag, " P (R3)"}, out_p, ep);
    chk({tag, " Q (R4)"}, out_q, eq);
    accept();
  endtask

  task automatic t_reset();
    chk("R1 out_valid", W'(out_valid), W'(0));
    chk("R1 in_ready", W'(in_ready), W'(1));
    chk("R1 P zero", out_p, '0);
    chk("R1 Q zero", out_q, '0);
  endtask

  task automatic t_single();
    logic [W-1:0] d;
    d = rnd_word();
    send(d, 1'b1);
    chk("R7 P single", out_p, d);
    chk("R7 Q single", out_q, d);
    chk("R2 first word loads Q", out_q, d);
    accept();
  endtask

  task automatic t_corner_bytes();
    logic [W-1:0] a, e;
    for (int i = 0; i < LANES; i++) begin
      case (i % 4)
        0: a[8*i +: 8] = 8'h80;
        1: a[8*i +: 8] = 8'hFF;
        2: a[8*i +: 8] = 8'h7F;
        default: a[8*i +: 8] = 8'h01;
      endcase
      case (i % 4)
        0: e[8*i +: 8] = 8'h1d;
        1: e[8*i +: 8] = 8'he3;
        2: e[8*i +: 8] = 8'hfe;
        default: e[8*i +: 8] = 8'h02;
      endcase
    end
    send(a, 1'b0);
    send('0, 1'b1);
    chk("R5 corner bytes Q", out_q, e);
    chk("R3 P with zero word", out_p, a);
    accept();
  endtask

  task automatic t_lane_isolation();
    logic [W-1:0] a;
    a = '0;
    a[8*3 +: 8] = 8'hC0;
    send(a, 1'b0);
    send('0, 1'b0);
    send('0, 1'b1);
    a = '0;
    a[8*3 +: 8] = 8'h27;
    chk("R6 lane isolation Q", out_q, a);
    accept();
  endtask

  task automatic t_stall();
    logic [W-1:0] d, hp, hq;
    d = rnd_word();
    send(d, 1'b0);
    send(rnd_word(), 1'b1);
    hp = out_p;
    hq = out_q;
    in_valid = 1'b1;
    in_data  = rnd_word();
    in_last  = 1'b1;
    chk("R9 in_ready low while pending", W'(in_ready), W'(0));
    repeat (3) @(negedge clk);
    in_valid = 1'b0;
    in_last  = 1'b0;
    chk("R8 out_valid held", W'(out_valid), W'(1));
    chk("R9 P unchanged by stalled word", out_p, hp);
    chk("R9 Q unchanged by stalled word", out_q, hq);
    accept();
    d = rnd_word();
    send(d, 1'b1);
    chk("R10 new stripe starts fresh P", out_p, d);
    chk("R10 new stripe starts fresh Q", out_q, d);
    accept();
  endtask

  task automatic t_mid_reset();
    logic [W-1:0] d;
    send(rnd_word(), 1'b0);
    send(rnd_word(), 1'b0);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk("R11 P cleared", out_p, '0);
    chk("R11 Q cleared", out_q, '0);
    d = rnd_word();
    send(d, 1'b1);
    chk("R11 first word after reset P", out_p, d);
    chk("R11 first word after reset Q", out_q, d);
    accept();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_single();
    run_stripe(2, "two disks");
    run_stripe(5, "five disks");
    run_stripe(14, "fourteen disks");
    t_corner_bytes();
    t_lane_isolation();
    t_stall();
    t_mid_reset();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule